// File: doc/BRIEF.md
# Bus Fault Classifier and Status-Word Builder

This block sits next to the bus interface of a pipelined processor core. Every bus-error event comes with the attributes of the cycle that failed. The block sorts the event into one of four fault classes, decides when the fault exception is raised, and assembles the 16-bit special status word that the exception stack frame will carry. The four classes are: released write, exception processing, multi-register transfer, and all other cycles.

A released write overlaps the next instruction, so the instruction that issued it cannot be restarted. Its fault is therefore held pending. It is taken at the next instruction boundary, or earlier if the running instruction asks for an operand access. Every other class raises the exception at once and aborts the current instruction. The fault address and the write-data buffer are captured when the bus error is reported. They are held for the stacking logic until the next accepted fault. A bus error that arrives while a fault is still unacknowledged is dropped and reported on an overflow pulse.

Top module: `fault_status_unit`

## Requirements
- R1: A bus error is class I (released) when `cyc_kind` is 6. It is also class I when `cyc_kind` is 3 (peripheral move) or 4 (multi-register move) with `cyc_rd`=0 and `cyc_last`=1. A class I fault raises no `exc_req` in the cycle after the bus error; it becomes pending.
- R2: While a class I fault is pending, an `insn_boundary` pulse raises `exc_req` one cycle later with `abort_insn`=0, `restore_req`=0 and `pc_next`=1.
- R3: While a class I fault is pending, an `opnd_req` pulse raises `exc_req` one cycle later with `abort_insn`=1 and `pc_next`=1. This holds even if `insn_boundary` is high in the same cycle.
- R4: Codes 0 (prefetch), 1 (operand read), 2 (read-modify-write) and 7 (other) raise `exc_req`, `abort_insn` and `restore_req` one cycle after the bus error, with `pc_next`=0. So do codes 3 and 4 when they are not the final write.
- R5: Code 5 (exception processing) raises `exc_req` and `abort_insn` one cycle after the bus error, with `restore_req`=0.
- R6: A code 4 fault that is not class I is taken at once with `restore_req`=1, and status-word bit 14 is set.
- R7: Status word for class I, bit 15 down to 0: 0, 0, 0, `trace_pend`, `pend_b1`, `pend_b0`, 1, 0, 0, 0, LG, SIZ[1:0], FUNC[2:0]. The three flags are sampled in the cycle the exception is taken. LG, SIZ and FUNC come from the faulted cycle.
- R8: Status word for the other classes: bit 15 = 0, bit 14 = multi-register class, bits 13 and 12 = 0, bit 11 = `pend_b1`, bit 10 = `pend_b0`, bit 9 = 0, bit 8 = (code 2), bit 7 = (code 0), bit 6 = `cyc_rd`, then LG, SIZ and FUNC. The status word holds its value until the next taken exception.
- R9: `stk_addr` and `stk_data` load `fault_addr` and `fault_wdata` one cycle after an accepted bus error and hold until the next accepted one.
- R10: A bus error is accepted only when no fault is pending or taken-but-unacknowledged. This includes the cycle in which `exc_ack` arrives. Otherwise the bus error is ignored, and `pend_ovf` pulses for one cycle one cycle later.
- R11: `exc_req` is a one-cycle pulse. `exc_ack` returns the block to idle. Synchronous reset clears all pulses, `ssw`, `pc_next` and the pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| berr | input | 1 | Bus error reported for the current cycle |
| cyc_kind | input | 3 | Kind of the faulted cycle (codes in R1, R4, R5) |
| cyc_rd | input | 1 | Faulted cycle was a read |
| cyc_last | input | 1 | Faulted cycle was the final transfer of a move |
| cyc_long | input | 1 | Long-operand attribute of the faulted cycle |
| cyc_size | input | 2 | Transfer size of the faulted cycle |
| cyc_func | input | 3 | Function code of the faulted cycle |
| fault_addr | input | ADDR_W | Address of the faulted cycle |
| fault_wdata | input | DATA_W | Write-data buffer of the faulted cycle |
| trace_pend | input | 1 | Trace exception pending |
| pend_b1 | input | 1 | Breakpoint-class exception pending (B1) |
| pend_b0 | input | 1 | Breakpoint-class exception pending (B0) |
| insn_boundary | input | 1 | Instruction boundary strobe |
| opnd_req | input | 1 | Operand access requested by the running instruction |
| exc_ack | input | 1 | Fault exception acknowledged |
| exc_req | output | 1 | Fault exception request, one-cycle pulse |
| abort_insn | output | 1 | Abort the current instruction |
| restore_req | output | 1 | Restore address registers changed by the effective-address step |
| ssw | output | 16 | Special status word |
| pc_next | output | 1 | Stacked PC is that of the next unexecuted instruction |
| stk_addr | output | ADDR_W | Captured fault address |
| stk_data | output | DATA_W | Captured write-data buffer |
| pend_ovf | output | 1 | Pulse: a bus error was dropped because a fault is outstanding |

## Verification
Two functions can fall in the same cycle: a pending released-write fault firing on a boundary or an operand request, and a fresh bus error. The bench drives both in one cycle. It expects the pending fault to be taken with its own latched attributes, the new bus error to be dropped with `pend_ovf` raised, and the stack address to stay unchanged. A second collision also occurs: an acknowledge and a new bus error in the same cycle. The new bus error must again be dropped with an overflow pulse. Random traffic mixes strobes and bus errors, and the reference model is compared on every output in every cycle.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
  localparam int SSW_W = 16;

  typedef enum logic [2:0] {
    K_PREFETCH = 3'd0,
    K_OPREAD   = 3'd1,
    K_RMW      = 3'd2,
    K_PMOVE    = 3'd3,
    K_MMOVE    = 3'd4,
    K_EXCPROC  = 3'd5,
    K_RELWR    = 3'd6,
    K_OTHER    = 3'd7
  } kind_t;

  typedef enum logic [1:0] {FC_REL, FC_EXC, FC_MREG, FC_GEN} fclass_t;

  typedef enum logic [1:0] {ST_IDLE, ST_PEND, ST_TAKEN} pst_t;

  typedef struct packed {
    logic       rd;
    logic       rmw;
    logic       ifetch;
    logic       lg;
    logic [1:0] siz;
    logic [2:0] func;
  } attr_t;
endpackage

// File: rtl/fsu_classify.sv
module fsu_classify
  import fsu_pkg::*;
(
  input  logic [2:0] kind,
  input  logic       rd,
  input  logic       last,
  input  logic       lg,
  input  logic [1:0] siz,
  input  logic [2:0] func,
  output fclass_t    cls,
  output attr_t      attr
);
  logic move_final_wr;

  always_comb begin
    move_final_wr = (kind == K_PMOVE || kind == K_MMOVE) && !rd && last;
    if (kind == K_RELWR || move_final_wr) cls = FC_REL;
    else if (kind == K_EXCPROC)           cls = FC_EXC;
    else if (kind == K_MMOVE)             cls = FC_MREG;
    else                                  cls = FC_GEN;
    attr.rd     = rd;
    attr.rmw    = (kind == K_RMW);
    attr.ifetch = (kind == K_PREFETCH);
    attr.lg     = lg;
    attr.siz    = siz;
    attr.func   = func;
  end
endmodule

// File: rtl/fsu_ssw.sv
module fsu_ssw
  import fsu_pkg::*;
(
  input  fclass_t          cls,
  input  attr_t            attr,
  input  logic             tr,
  input  logic             b1,
  input  logic             b0,
  output logic [SSW_W-1:0] word
);
  logic rel;

  always_comb begin
    rel       = (cls == FC_REL);
    word      = '0;
    word[14]  = (cls == FC_MREG);
    word[12]  = rel & tr;
    word[11]  = b1;
    word[10]  = b0;
    word[9]   = rel;
    word[8]   = !rel & attr.rmw;
    word[7]   = !rel & attr.ifetch;
    word[6]   = !rel & attr.rd;
    word[5]   = attr.lg;
    word[4:3] = attr.siz;
    word[2:0] = attr.func;
  end
endmodule

// File: rtl/fsu_pend.sv
module fsu_pend
  import fsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              berr,
  input  logic              is_rel,
  input  attr_t             attr_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              boundary,
  input  logic              opnd,
  input  logic              ack,
  output logic              take_now,
  output logic              fire,
  output logic              ovf_evt,
  output attr_t             attr_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);
  pst_t st;
  logic accept;

  always_comb begin
    accept   = berr && (st == ST_IDLE);
    take_now = accept && !is_rel;
    fire     = (st == ST_PEND) && !ack && (boundary || opnd);
    ovf_evt  = berr && (st != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      attr_q <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      unique case (st)
        ST_IDLE:  if (accept) st <= is_rel ? ST_PEND : ST_TAKEN;
        ST_PEND:  if (ack) st <= ST_IDLE; else if (fire) st <= ST_TAKEN;
        default:  if (ack) st <= ST_IDLE;
      endcase
      if (accept) begin
        attr_q <= attr_in;
        addr_q <= addr_in;
        data_q <= data_in;
      end
    end
  end

  // R1
  hold_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PEND && !ack && !boundary && !opnd) |=> (st == ST_PEND));

  // R10
  drop_keeps_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (berr && st != ST_IDLE) |=> $stable(addr_q) && $stable(data_q));
endmodule

// File: rtl/fault_status_unit.sv
module fault_status_unit
  import fsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              berr,
  input  logic [2:0]        cyc_kind,
  input  logic              cyc_rd,
  input  logic              cyc_last,
  input  logic              cyc_long,
  input  logic [1:0]        cyc_size,
  input  logic [2:0]        cyc_func,
  input  logic [ADDR_W-1:0] fault_addr,
  input  logic [DATA_W-1:0] fault_wdata,
  input  logic              trace_pend,
  input  logic              pend_b1,
  input  logic              pend_b0,
  input  logic              insn_boundary,
  input  logic              opnd_req,
  input  logic              exc_ack,
  output logic              exc_req,
  output logic              abort_insn,
  output logic              restore_req,
  output logic [15:0]       ssw,
  output logic              pc_next,
  output logic [ADDR_W-1:0] stk_addr,
  output logic [DATA_W-1:0] stk_data,
  output logic              pend_ovf
);
  fclass_t          live_cls, sel_cls;
  attr_t            live_attr, held_attr, sel_attr;
  logic             take_now, fire, ovf_evt;
  logic [SSW_W-1:0] built;

  fsu_classify u_cls (
    .kind(cyc_kind), .rd(cyc_rd), .last(cyc_last), .lg(cyc_long),
    .siz(cyc_size), .func(cyc_func), .cls(live_cls), .attr(live_attr)
  );

  fsu_pend #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pend (
    .clk(clk), .rst(rst), .berr(berr), .is_rel(live_cls == FC_REL),
    .attr_in(live_attr), .addr_in(fault_addr), .data_in(fault_wdata),
    .boundary(insn_boundary), .opnd(opnd_req), .ack(exc_ack),
    .take_now(take_now), .fire(fire), .ovf_evt(ovf_evt),
    .attr_q(held_attr), .addr_q(stk_addr), .data_q(stk_data)
  );

  always_comb begin
    sel_cls  = fire ? FC_REL : live_cls;
    sel_attr = fire ? held_attr : live_attr;
  end

  fsu_ssw u_ssw (
    .cls(sel_cls), .attr(sel_attr), .tr(trace_pend),
    .b1(pend_b1), .b0(pend_b0), .word(built)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_req     <= 1'b0;
      abort_insn  <= 1'b0;
      restore_req <= 1'b0;
      ssw         <= '0;
      pc_next     <= 1'b0;
      pend_ovf    <= 1'b0;
    end else begin
      exc_req     <= take_now || fire;
      abort_insn  <= take_now || (fire && opnd_req);
      restore_req <= take_now && (live_cls != FC_EXC);
      pend_ovf    <= ovf_evt;
      if (take_now || fire) begin
        ssw     <= built;
        pc_next <= fire;
      end
    end
  end

  // R11
  exc_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    exc_req |=> !exc_req);

  // R3
  abort_with_exc_chk: assert property (@(posedge clk) disable iff (rst)
    abort_insn |-> exc_req);

  // R4
  restore_immediate_chk: assert property (@(posedge clk) disable iff (rst)
    restore_req |-> (exc_req && !pc_next));

  // R7
  rel_word_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_req && pc_next) |-> (ssw[15:13] == 3'b000 && ssw[9] && ssw[8:6] == 3'b000));

  // R10
  ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    pend_ovf |-> $past(berr));
endmodule

// File: tb/sim_fault_status_unit.sv
module sim_fault_status_unit;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 0, rst = 1;
  logic berr = 0, cyc_rd = 0, cyc_last = 0, cyc_long = 0;
  logic [2:0] cyc_kind = 0, cyc_func = 0;
  logic [1:0] cyc_size = 0;
  logic [AW-1:0] fault_addr = 0;
  logic [DW-1:0] fault_wdata = 0;
  logic trace_pend = 0, pend_b1 = 0, pend_b0 = 0;
  logic insn_boundary = 0, opnd_req = 0, exc_ack = 0;
  logic exc_req, abort_insn, restore_req, pc_next, pend_ovf;
  logic [15:0] ssw;
  logic [AW-1:0] stk_addr;
  logic [DW-1:0] stk_data;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fault_status_unit #(.ADDR_W(AW), .DATA_W(DW)) u0 (.*);

  // behavioural reference: 0 idle, 1 pending, 2 taken
  int m_st;
  bit m_exc, m_abort, m_rest, m_pcn, m_ovf;
  bit [15:0] m_ssw;
  bit [AW-1:0] m_addr;
  bit [DW-1:0] m_data;
  bit l_rd, l_rmw, l_inf, l_lg;
  bit [1:0] l_siz;
  bit [2:0] l_fn;

  function automatic bit [15:0] mk_word(bit rel, bit mv, bit tr, bit b1, bit b0,
      bit rd, bit rmw, bit inf, bit lg, bit [1:0] siz, bit [2:0] fn);
    return {1'b0, mv, 1'b0, rel & tr, b1, b0, rel,
            rel ? 1'b0 : rmw, rel ? 1'b0 : inf, rel ? 1'b0 : rd, lg, siz, fn};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_exc = 0; m_abort = 0; m_rest = 0; m_pcn = 0; m_ovf = 0;
      m_ssw = 0; m_addr = 0; m_data = 0;
      {l_rd, l_rmw, l_inf, l_lg, l_siz, l_fn} = '0;
    end else begin
      bit rel;
      rel = (cyc_kind == 6) || ((cyc_kind == 3 || cyc_kind == 4) && !cyc_rd && cyc_last);
      m_ovf = berr && (m_st != 0);
      m_exc = 0; m_abort = 0; m_rest = 0;
      if (m_st == 0) begin
        if (berr) begin
          m_addr = fault_addr; m_data = fault_wdata;
          l_rd = cyc_rd; l_rmw = (cyc_kind == 2); l_inf = (cyc_kind == 0);
          l_lg = cyc_long; l_siz = cyc_size; l_fn = cyc_func;
          if (rel) m_st = 1;
          else begin
            m_exc = 1; m_abort = 1; m_rest = (cyc_kind != 5); m_pcn = 0;
            m_ssw = mk_word(0, cyc_kind == 4, trace_pend, pend_b1, pend_b0,
                            l_rd, l_rmw, l_inf, l_lg, l_siz, l_fn);
            m_st = 2;
          end
        end
      end else if (m_st == 1) begin
        if (exc_ack) m_st = 0;
        else if (insn_boundary || opnd_req) begin
          m_exc = 1; m_abort = opnd_req; m_pcn = 1;
          m_ssw = mk_word(1, 0, trace_pend, pend_b1, pend_b0,
                          l_rd, l_rmw, l_inf, l_lg, l_siz, l_fn);
          m_st = 2;
        end
      end else if (exc_ack) m_st = 0;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R11 exc_req", exc_req, m_exc);
    chk("R3 abort_insn", abort_insn, m_abort);
    chk("R4 restore_req", restore_req, m_rest);
    chk(m_pcn ? "R7 ssw" : "R8 ssw", ssw, m_ssw);
    chk("R2 pc_next", pc_next, m_pcn);
    chk("R9 stk_addr", stk_addr, m_addr);
    chk("R9 stk_data", stk_data, m_data);
    chk("R10 pend_ovf", pend_ovf, m_ovf);
  endtask

  task automatic tick();
    @(posedge clk); #2; compare_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic fault(logic [2:0] k, logic rd, logic last);
    cyc_kind = k; cyc_rd = rd; cyc_last = last;
    cyc_long = 1'($urandom); cyc_size = 2'($urandom); cyc_func = 3'($urandom);
    fault_addr = $urandom; fault_wdata = $urandom;
    berr = 1; tick(); berr = 0;
  endtask

  task automatic ack();
    exc_ack = 1; tick(); exc_ack = 0;
  endtask

  initial begin
    idle(3);
    rst = 0;
    // R11 reset state
    chk("R11 reset exc_req", exc_req, 0);
    chk("R11 reset ssw", ssw, 0);
    idle(1);
    // R4 immediate classes
    fault(0, 1, 0); ack();
    fault(1, 1, 0); ack();
    fault(2, 1, 0); ack();
    fault(3, 1, 0); ack();
    fault(7, 0, 0); ack();
    // R5
    fault(5, 1, 0);
    chk("R5 restore_req", restore_req, 0);
    chk("R5 exc_req", exc_req, 1);
    ack();
    // R6
    fault(4, 0, 0);
    chk("R6 ssw[14]", ssw[14], 1);
    ack();
    // R1 then R2
    trace_pend = 1; pend_b1 = 1;
    fault(6, 0, 0);
    chk("R1 exc_req held", exc_req, 0);
    idle(3);
    insn_boundary = 1; tick(); insn_boundary = 0;
    chk("R2 pc_next", pc_next, 1);
    chk("R7 ssw rr bit", ssw[9], 1);
    ack();
    // R3 with final write of peripheral move
    trace_pend = 0; pend_b0 = 1;
    fault(3, 0, 1); idle(1);
    opnd_req = 1; insn_boundary = 1; tick(); opnd_req = 0; insn_boundary = 0;
    chk("R3 abort_insn", abort_insn, 1);
    ack();
    // R10 dropped bus error while pending
    fault(4, 0, 1);
    fault(0, 1, 0);
    chk("R10 pend_ovf", pend_ovf, 1);
    // fire and new bus error in the same cycle
    insn_boundary = 1; fault(1, 1, 0); insn_boundary = 0;
    chk("R10 collide ovf", pend_ovf, 1);
    chk("R2 collide exc", exc_req, 1);
    // bus error on the acknowledge cycle
    exc_ack = 1; fault(2, 1, 0); exc_ack = 0;
    chk("R10 ack collide", pend_ovf, 1);
    idle(2);
    // random traffic
    for (int i = 0; i < 600; i++) begin
      berr = ($urandom % 4) == 0;
      cyc_kind = 3'($urandom); cyc_rd = 1'($urandom); cyc_last = 1'($urandom);
      cyc_long = 1'($urandom); cyc_size = 2'($urandom); cyc_func = 3'($urandom);
      fault_addr = $urandom; fault_wdata = $urandom;
      trace_pend = 1'($urandom); pend_b1 = 1'($urandom); pend_b0 = 1'($urandom);
      insn_boundary = ($urandom % 4) == 0;
      opnd_req = ($urandom % 6) == 0;
      exc_ack = ($urandom % 8) == 0;
      tick();
    end
    berr = 0; exc_ack = 0; insn_boundary = 0; opnd_req = 0;
    idle(2);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule